// File: doc/BRIEF.md
# Comparator Result Conditioner with Edge Interrupt

This block takes the one-bit decision of an analog voltage comparator, which arrives with no timing relation to the local clock. It turns that decision into a clean, clocked level. The input first passes through a synchronizer. An optional noise filter follows. It accepts a new level only after three agreeing samples, taken at the base clock rate or at the base rate divided by 8 or 32. The conditioned level drives two things. One is an interrupt request that fires on rising edges, falling edges or both. The other is an output pin that carries the level with selectable inversion and can be forced low.

Software sets the block up through two small write-only registers. Address 0 holds the master enable, the filter mode and the edge selection. Any write to address 0 also flushes the filter's sample history and re-arms the edge detector. Address 1 holds the pin polarity, the pin enable and the interrupt enable.

Top module: `cmp_cond_top`

## Requirements
- R1: With the filter mode field (address 0, bits 2:1) at 00, a change on `cmp_raw_i` set up before clock edge k appears on `pin_o` after edge k+2 (two synchronizer flops, then the level register), and `irq_o` pulses in that same cycle when the edge qualifies.
- R2: With the edge field (address 0, bits 4:3) at 00, only rising transitions of the conditioned level raise `irq_o`.
- R3: With the edge field at 01, only falling transitions raise `irq_o`.
- R4: With the upper bit of the edge field set (10 or 11), both transitions raise `irq_o`.
- R5: With the invert bit (address 1, bit 0) at 1, `pin_o` carries the complement of the conditioned level; at 0 it carries the level unchanged.
- R6: With the pin enable bit (address 1, bit 1) at 0, `pin_o` stays low whatever the input; all outputs are low after reset.
- R7: With the interrupt enable bit (address 1, bit 2) at 0, no transition produces an `irq_o` pulse.
- R8: While the enable bit (address 0, bit 0) is 0, input changes alter neither `pin_o` nor `irq_o`.
- R9: In filter mode 01, the level changes only on the third consecutive per-cycle sample that agrees with it, so `pin_o` follows after edge k+4, and a two-cycle input pulse is discarded.
- R10: In filter mode 10 (one sample every 8 cycles), a 10-cycle input pulse is discarded and a 40-cycle pulse is passed.
- R11: In filter mode 11 (one sample every 32 cycles), a 40-cycle pulse is discarded and a 120-cycle pulse is passed; the sampling prescaler restarts from zero while the block is disabled.
- R12: A write to address 0 discards all samples taken so far, so three fresh agreeing samples are needed after it before the level can change.
- R13: Each isolated transition of the conditioned level gives an `irq_o` pulse exactly one clock wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_raw_i | input | 1 | Asynchronous comparator decision |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Register select: 0 mode, 1 output control |
| wr_data_i | input | 8 | Register write data |
| pin_o | output | 1 | Gated, polarity-selected conditioned level |
| irq_o | output | 1 | One-cycle interrupt request |

## Verification
The hardest case to reach from the ports is a configuration write that lands while the filter holds some but not all of the samples it needs. Its effect shows only as a delay in the level change. The bench gives the input a clean step in the per-cycle filter mode and lets exactly two samples build up. It then writes the mode register on the very edge where the third sample would have been taken. It checks that the pin holds through the next two edges and changes on the edge after them. For the divided rates, the prescaler phase cannot be seen from the ports, so the bench uses pulse lengths that must be dropped or kept at any phase.

// File: rtl/cmpc_pkg.sv
// Shared types for the comparator conditioner.
// Assumes: register fields are packed LSB-first into the write word.
package cmpc_pkg;

    typedef enum logic [1:0] {
        FILT_OFF   = 2'b00,
        FILT_BASE  = 2'b01,
        FILT_DIV8  = 2'b10,
        FILT_DIV32 = 2'b11
    } filt_sel_e;

    // Address 0: {edge_sel[1:0], filt[1:0], en}
    typedef struct packed {
        logic [1:0] edge_sel;
        filt_sel_e  filt;
        logic       en;
    } mode_reg_t;

    // Address 1: {irq_en, pin_oe, invert}
    typedef struct packed {
        logic irq_en;
        logic pin_oe;
        logic invert;
    } outc_reg_t;

endpackage

// File: rtl/cmpc_regs.sv
// Control register file: two write-only registers selected by one address bit.
// Assumes: DATA_W covers both register layouts; spare data bits are dropped.
// Emits cfg_clr_o for the cycle in which address 0 is written.
module cmpc_regs
    import cmpc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output mode_reg_t         mode_o,
    output outc_reg_t         outc_o,
    output logic              cfg_clr_o
);
    localparam int MODE_W = $bits(mode_reg_t);
    localparam int OUTC_W = $bits(outc_reg_t);

    mode_reg_t mode_q;
    outc_reg_t outc_q;
    logic      unused_spare;

    assign unused_spare = ^wr_data_i[DATA_W-1:MODE_W];

    // Capture writes into the selected register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            outc_q <= '0;
        end else if (wr_en_i) begin
            if (!wr_addr_i) mode_q <= mode_reg_t'(wr_data_i[MODE_W-1:0]);
            else            outc_q <= outc_reg_t'(wr_data_i[OUTC_W-1:0]);
        end
    end

    assign cfg_clr_o = wr_en_i && !wr_addr_i;
    assign mode_o    = mode_q;
    assign outc_o    = outc_q;

endmodule

// File: rtl/cmpc_sync.sv
// Multi-flop synchronizer for the asynchronous comparator decision.
// Assumes: STAGES >= 2; the input is a slow level, not a pulse.
module cmpc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/cmpc_filter.sv
// Majority-free agreement filter with a prescaled sample strobe.
// Bypass mode copies the synchronized input each cycle. Filter modes take a
// sample on each strobe and move the level only when AGREE consecutive
// samples match. Assumes: DIV_MID and DIV_SLOW are powers of two with
// DIV_MID < DIV_SLOW, and AGREE >= 3. Disable or a mode write flushes the
// history and holds the level.
module cmpc_filter
    import cmpc_pkg::*;
#(
    parameter int DIV_MID  = 8,
    parameter int DIV_SLOW = 32,
    parameter int AGREE    = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en_i,
    input  logic      clr_i,
    input  filt_sel_e filt_sel_i,
    input  logic      sync_i,
    output logic      level_o
);
    localparam int PRE_W  = $clog2(DIV_SLOW);
    localparam int MID_W  = $clog2(DIV_MID);
    localparam int HIST_W = AGREE - 1;
    localparam int CNT_W  = $clog2(AGREE);

    logic [PRE_W-1:0]  pre_q;
    logic [HIST_W-1:0] hist_q;
    logic [CNT_W-1:0]  vcnt_q;
    logic              level_q;
    logic              stb_mid, stb_slow, strobe, agree;

    // Free-running prescaler, restarted while disabled or on a mode write.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i || clr_i)              pre_q <= '0;
        else if (pre_q == PRE_W'(DIV_SLOW - 1))    pre_q <= '0;
        else                                       pre_q <= pre_q + 1'b1;
    end

    assign stb_mid  = &pre_q[MID_W-1:0];
    assign stb_slow = (pre_q == PRE_W'(DIV_SLOW - 1));

    // Pick the sample strobe for the selected mode.
    always_comb begin
        case (filt_sel_i)
            FILT_BASE:  strobe = 1'b1;
            FILT_DIV8:  strobe = stb_mid;
            FILT_DIV32: strobe = stb_slow;
            default:    strobe = 1'b0;
        endcase
    end

    assign agree = (vcnt_q == CNT_W'(HIST_W)) && (hist_q == {HIST_W{sync_i}});

    // Sample history, valid count and the conditioned level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q  <= '0;
            vcnt_q  <= '0;
            level_q <= 1'b0;
        end else if (!en_i || clr_i) begin
            hist_q <= '0;
            vcnt_q <= '0;
        end else if (filt_sel_i == FILT_OFF) begin
            level_q <= sync_i;
            vcnt_q  <= '0;
        end else if (strobe) begin
            hist_q <= {hist_q[HIST_W-2:0], sync_i};
            if (vcnt_q != CNT_W'(HIST_W)) vcnt_q <= vcnt_q + 1'b1;
            if (agree) level_q <= sync_i;
        end
    end

    assign level_o = level_q;

    p_bypass_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && filt_sel_i == FILT_OFF && !clr_i) |=> (level_q == $past(sync_i)));

    p_hold_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(level_q));

    p_filt_takes_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && filt_sel_i != FILT_OFF && !clr_i)
            |=> (level_q == $past(level_q)) || (level_q == $past(sync_i)));

    p_pre_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (pre_q == '0));

endmodule

// File: rtl/cmpc_edge.sv
// Edge detector for the conditioned level and the interrupt request.
// The previous-level register always tracks the level, so a held level
// never looks like an edge. Assumes: edge_sel_i[1] set means both edges.
module cmpc_edge (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       clr_i,
    input  logic       irq_en_i,
    input  logic [1:0] edge_sel_i,
    input  logic       level_i,
    output logic       irq_o
);
    logic prev_q, rise, fall, match;

    // Remember the level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_i;
    end

    assign rise = level_i && !prev_q;
    assign fall = !level_i && prev_q;

    // Qualify the transition against the selected edge.
    always_comb begin
        if (edge_sel_i[1])      match = rise || fall;
        else if (edge_sel_i[0]) match = fall;
        else                    match = rise;
    end

    assign irq_o = en_i && irq_en_i && !clr_i && match;

    p_irq_on_change_r13: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (level_i != $past(level_i)));

endmodule

// File: rtl/cmp_cond_top.sv
// Comparator result conditioner: synchronizer, sample filter, edge
// interrupt and gated polarity pin output around one comparator decision.
// Assumes: the comparator input is asynchronous; all else is on clk.
module cmp_cond_top
    import cmpc_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_MID     = 8,
    parameter int DIV_SLOW    = 32,
    parameter int AGREE       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_raw_i,
    input  logic              wr_en_i,
    input  logic              wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              pin_o,
    output logic              irq_o
);
    mode_reg_t mode;
    outc_reg_t outc;
    logic      cfg_clr, sync_lvl, level;

    cmpc_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .mode_o    (mode),
        .outc_o    (outc),
        .cfg_clr_o (cfg_clr)
    );

    cmpc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cmp_raw_i),
        .q_o   (sync_lvl)
    );

    cmpc_filter #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW), .AGREE(AGREE)) u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (mode.en),
        .clr_i      (cfg_clr),
        .filt_sel_i (mode.filt),
        .sync_i     (sync_lvl),
        .level_o    (level)
    );

    cmpc_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (mode.en),
        .clr_i      (cfg_clr),
        .irq_en_i   (outc.irq_en),
        .edge_sel_i (mode.edge_sel),
        .level_i    (level),
        .irq_o      (irq_o)
    );

    // Pin: enable-gated, polarity-selected copy of the conditioned level.
    assign pin_o = outc.pin_oe && (level ^ outc.invert);

    p_pin_follows_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(level) && $stable(outc)) |-> $stable(pin_o));

endmodule

// File: tb/cmp_cond_top_tb.sv
module cmp_cond_top_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmp_raw_i;
    logic       wr_en_i;
    logic       wr_addr_i;
    logic [7:0] wr_data_i;
    logic       pin_o;
    logic       irq_o;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    int irq_run = 0;
    int irq_max = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cmp_cond_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_raw_i (cmp_raw_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .pin_o     (pin_o),
        .irq_o     (irq_o)
    );

    // Count request pulses and their width, sampled away from the rising edge.
    always @(negedge clk) begin
        if (irq_o) begin
            irq_cnt <= irq_cnt + 1;
            irq_run <= irq_run + 1;
            if (irq_run + 1 > irq_max) irq_max <= irq_run + 1;
        end else begin
            irq_run <= 0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input bit a, input logic [7:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    // Bypass latency and rising-only selection.
    task automatic t_bypass();
        int c0;
        wr(1'b1, 8'h06);
        wr(1'b0, 8'h01);
        step(5);
        c0 = irq_cnt;
        cmp_raw_i = 1'b1;
        step(2);
        chk("R1 pin before edge k+2", pin_o, 0);
        step(1);
        chk("R1 pin after edge k+2", pin_o, 1);
        chk("R1 irq same cycle", irq_o, 1);
        step(1);
        chk("R13 irq one cycle", irq_o, 0);
        cmp_raw_i = 1'b0;
        step(6);
        chk("R2 rising only", irq_cnt - c0, 1);
    endtask

    task automatic t_edge(input logic [1:0] sel, input int exp_r, input int exp_f, input string tag);
        int c0;
        wr(1'b0, {3'b000, sel, 2'b00, 1'b1});
        step(3);
        c0 = irq_cnt;
        cmp_raw_i = 1'b1;
        step(6);
        chk({tag, " rise count"}, irq_cnt - c0, exp_r);
        c0 = irq_cnt;
        cmp_raw_i = 1'b0;
        step(6);
        chk({tag, " fall count"}, irq_cnt - c0, exp_f);
    endtask

    // Polarity, pin gating and interrupt enable.
    task automatic t_outputs();
        int c0;
        wr(1'b0, 8'h19);
        wr(1'b1, 8'h03);
        step(3);
        c0 = irq_cnt;
        chk("R5 inverted low level", pin_o, 1);
        cmp_raw_i = 1'b1;
        step(6);
        chk("R5 inverted high level", pin_o, 0);
        cmp_raw_i = 1'b0;
        step(6);
        chk("R7 no irq when disabled", irq_cnt - c0, 0);
        wr(1'b1, 8'h04);
        cmp_raw_i = 1'b1;
        step(6);
        chk("R6 pin held low, level high", pin_o, 0);
        cmp_raw_i = 1'b0;
        step(6);
        chk("R6 pin held low, level low", pin_o, 0);
        wr(1'b1, 8'h06);
        step(2);
    endtask

    // Master enable freezes level and requests.
    task automatic t_enable();
        int c0;
        wr(1'b0, 8'h19);
        cmp_raw_i = 1'b1;
        step(6);
        chk("R8 enabled level high", pin_o, 1);
        wr(1'b0, 8'h18);
        c0 = irq_cnt;
        cmp_raw_i = 1'b0;
        step(10);
        chk("R8 pin frozen", pin_o, 1);
        cmp_raw_i = 1'b1;
        step(3);
        cmp_raw_i = 1'b0;
        step(10);
        chk("R8 no irq while off", irq_cnt - c0, 0);
        chk("R8 pin still frozen", pin_o, 1);
        wr(1'b0, 8'h19);
        step(4);
        chk("R8 resumes after enable", pin_o, 0);
        step(4);
    endtask

    // Per-cycle filter: agreement latency and glitch rejection.
    task automatic t_base_filter();
        int c0;
        wr(1'b0, 8'h1B);
        step(6);
        c0 = irq_cnt;
        cmp_raw_i = 1'b1;
        step(2);
        cmp_raw_i = 1'b0;
        step(8);
        chk("R9 short pulse dropped pin", pin_o, 0);
        chk("R9 short pulse dropped irq", irq_cnt - c0, 0);
        cmp_raw_i = 1'b1;
        step(4);
        chk("R9 pin before third sample", pin_o, 0);
        step(1);
        chk("R9 pin after third sample", pin_o, 1);
        cmp_raw_i = 1'b0;
        step(10);
    endtask

    task automatic t_div(input logic [7:0] cfg, input int short_len, input int long_len, input string tag);
        int c0;
        wr(1'b0, cfg);
        step(4 * long_len);
        c0 = irq_cnt;
        cmp_raw_i = 1'b1;
        step(short_len);
        cmp_raw_i = 1'b0;
        step(2 * long_len);
        chk({tag, " short pulse dropped"}, pin_o, 0);
        chk({tag, " short pulse no irq"}, irq_cnt - c0, 0);
        cmp_raw_i = 1'b1;
        step(long_len);
        chk({tag, " long pulse passed"}, pin_o, 1);
        chk({tag, " long pulse irq"}, irq_cnt - c0, 1);
        cmp_raw_i = 1'b0;
        step(long_len);
    endtask

    // Mode write flushes partial sample history.
    task automatic t_clear();
        wr(1'b0, 8'h1B);
        step(6);
        cmp_raw_i = 1'b1;
        step(4);
        wr(1'b0, 8'h1B);
        chk("R12 no change at flushed edge", pin_o, 0);
        step(2);
        chk("R12 still waiting for fresh samples", pin_o, 0);
        step(1);
        chk("R12 change after three fresh samples", pin_o, 1);
        cmp_raw_i = 1'b0;
        step(8);
    endtask

    initial begin
        rst_n = 1'b0; cmp_raw_i = 1'b0;
        wr_en_i = 1'b0; wr_addr_i = 1'b0; wr_data_i = '0;
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R6 reset pin", pin_o, 0);
        chk("R6 reset irq", irq_o, 0);
        t_bypass();
        t_edge(2'b00, 1, 0, "R2");
        t_edge(2'b01, 0, 1, "R3");
        t_edge(2'b10, 1, 1, "R4 sel10");
        t_edge(2'b11, 1, 1, "R4 sel11");
        t_outputs();
        t_enable();
        t_base_filter();
        t_div(8'h1D, 10, 40, "R10");
        t_div(8'h1F, 40, 120, "R11");
        t_clear();
        chk("R13 max irq width", irq_max, 1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(10 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule